// File: doc/BRIEF.md
# Serial Bootloader Memory-Write Responder

This block is the target side of a byte-oriented serial loader link. A host opens a session with a two-byte sync pattern. It then sends write chunks, each made of a command pair, a checked 32-bit address, a length byte, the payload and a payload check byte. At the end it sends a go command. The responder answers every stage with a single status byte: acknowledge `0x79` or reject `0x1F`. The host moves to the next stage only after it has read that answer.

Payload bytes are first held in a chunk store. They are written to memory only after the chunk's check byte has matched, so a rejected chunk leaves memory untouched. The write is one byte per cycle to consecutive addresses. The host retries a rejected chunk by resending it from the command pair.

Replies are polled. The host raises `tx_poll` for one cycle and reads `tx_data` in that cycle. A reply byte is removed from the queue only while one is pending. At all other times, including during a commit, `tx_data` reads `0x00`, which tells the host the responder is busy.

States: `ST_SYNC_LO` (wait for `0x00`), `ST_SYNC_HI` (expect `0xFF`), `ST_CMD_A` and `ST_CMD_B` (command pair), `ST_ADDR` (four address bytes, then the XOR byte), `ST_LEN`, `ST_DATA`, `ST_DCHK`, `ST_COMMIT` and `ST_REPLY`.

Transitions:
- `ST_SYNC_LO` goes to `ST_SYNC_HI` on `0x00`.
- `ST_SYNC_HI` goes to `ST_REPLY` on any byte. Its return state is `ST_CMD_A` after a good sync and `ST_SYNC_LO` after a bad one.
- `ST_CMD_A` goes to `ST_CMD_B` on any byte.
- `ST_CMD_B` goes to `ST_REPLY` on any byte. It returns to `ST_ADDR` for a write, `ST_SYNC_LO` for go, and `ST_CMD_A` on a reject.
- `ST_ADDR` goes to `ST_REPLY` on the fifth byte. It returns to `ST_LEN` if the XOR byte matches, else to `ST_CMD_A`.
- `ST_LEN` goes to `ST_REPLY`. It returns to `ST_DATA` for a length of 1 to 0x80, else to `ST_CMD_A`.
- `ST_DATA` goes to `ST_DCHK` after the last payload byte.
- `ST_DCHK` goes to `ST_COMMIT` if the check byte matches, else to `ST_REPLY` with return state `ST_CMD_A`.
- `ST_COMMIT` goes to `ST_REPLY` after the last write, with return state `ST_CMD_A`.
- `ST_REPLY` goes to its return state when the last queued byte is polled.

Top module: `boot_write_responder`

## Requirements
- R1: After reset `rx_ready` is 1, `tx_data` is `0x00` and `mem_we` is 0.
- R2: A byte other than `0x00` in sync wait is ignored. `0x00` followed by `0xFF` is answered with `0x79`, then the 7 bytes of `INFO_WORD` most significant first. `0x00` followed by any other byte is answered with `0x1F`, and the responder then waits for sync again.
- R3: The command pair `0x31 0xCE` is answered with `0x79`. Any pair other than the write pair or the go pair is answered with `0x1F`, and the responder waits for a new command.
- R4: The address is four bytes, most significant first, then a fifth byte. If the fifth byte equals the XOR of the four, the answer is `0x79`. Otherwise it is `0x1F` and the responder returns to command wait.
- R5: A length byte from 1 to 0x80 is answered with `0x79`. A length of 0 or above 0x80 is answered with `0x1F` and the responder returns to command wait.
- R6: The byte after the payload must equal the length XOR every payload byte. On a mismatch the answer is `0x1F` and no memory write occurs.
- R7: When the check byte matches, payload byte i is written to the checked address plus i, one byte per cycle in order, before the answer `0x79` becomes readable.
- R8: `tx_data` is `0x00` whenever no reply is pending, including during a commit. `rx_ready` is 0 while a reply is pending or a commit is running. A pending reply byte stays on `tx_data` until it is polled.
- R9: The go pair `0x21 0xDE` is answered with `0x79`, then `0x51`, and the session closes. Further bytes are then ignored until a new sync.
- R10: After any reject, a complete write chunk sent next is accepted and committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Host byte is present |
| rx_data | input | 8 | Host byte |
| rx_ready | output | 1 | Responder takes a byte this cycle |
| tx_poll | input | 1 | Host reads `tx_data` this cycle |
| tx_data | output | 8 | Pending reply byte, or `0x00` when busy or idle |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | 32 | Memory write address |
| mem_wdata | output | 8 | Memory write data |

## Verification
The bench goes after several corner cases, each tied to a specific wrong behaviour:
- A chunk with a bad payload check. A design that writes payload bytes as they arrive would show writes that the model never expected.
- Lengths 0, 0x81 and 0x80. An off-by-one in the length limit would accept or reject the wrong one of these.
- A full 128-byte chunk. A responder that answers before the commit ends would never show the `0x00` busy reads.
- A bad address check byte, a bad sync and an unknown command, each followed by a retry. A design that did not return to command wait would refuse the retry.
- Bytes sent after go. A design that does not close the session would react to them.

// File: rtl/bwr_pkg.sv
package bwr_pkg;

    typedef enum logic [3:0] {
        ST_SYNC_LO,
        ST_SYNC_HI,
        ST_CMD_A,
        ST_CMD_B,
        ST_ADDR,
        ST_LEN,
        ST_DATA,
        ST_DCHK,
        ST_COMMIT,
        ST_REPLY
    } bwr_state_e;

    typedef enum logic [2:0] {
        RP_NONE,
        RP_ACK,
        RP_NACK,
        RP_SYNC,
        RP_GO
    } bwr_reply_e;

    localparam logic [7:0] BYTE_ACK  = 8'h79;
    localparam logic [7:0] BYTE_NACK = 8'h1F;
    localparam logic [7:0] BYTE_FIN  = 8'h51;
    localparam logic [7:0] SYNC_LO_B = 8'h00;
    localparam logic [7:0] SYNC_HI_B = 8'hFF;
    localparam logic [7:0] WR_OP     = 8'h31;
    localparam logic [7:0] WR_OP_N   = 8'hCE;
    localparam logic [7:0] GO_OP     = 8'h21;
    localparam logic [7:0] GO_OP_N   = 8'hDE;

endpackage

// File: rtl/bwr_chunk_store.sv
module bwr_chunk_store #(
    parameter int DEPTH = 128,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [7:0]    wr_byte,
    input  logic [IW-1:0] rd_idx,
    output logic [7:0]    rd_byte
);

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_idx] <= wr_byte;
        end
    end

    assign rd_byte = cells[rd_idx];

endmodule

// File: rtl/bwr_reply_queue.sv
module bwr_reply_queue #(
    parameter int DEPTH = 8,
    localparam int W  = DEPTH * 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [W-1:0]  load_bytes,
    input  logic [CW-1:0] load_cnt,
    input  logic          pop,
    output logic [7:0]    head,
    output logic          last
);

    logic [W-1:0]  shreg;
    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            left  <= '0;
        end else if (load) begin
            shreg <= load_bytes;
            left  <= load_cnt;
        end else if (pop && left != '0) begin
            shreg <= shreg << 8;
            left  <= left - 1'b1;
        end
    end

    assign head = shreg[W-1 -: 8];
    assign last = (left == CW'(1));

endmodule

// File: rtl/boot_write_responder.sv
module boot_write_responder
    import bwr_pkg::*;
#(
    parameter int                         MAX_CHUNK  = 128,
    parameter int                         INFO_BYTES = 7,
    parameter logic [INFO_BYTES*8-1:0]    INFO_WORD  = 56'h42_10_00_00_5A_A5_3C
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    output logic        rx_ready,
    input  logic        tx_poll,
    output logic [7:0]  tx_data,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [7:0]  mem_wdata
);

    localparam int         IDX_W    = (MAX_CHUNK > 1) ? $clog2(MAX_CHUNK) : 1;
    localparam int         RQ_DEPTH = INFO_BYTES + 1;
    localparam int         RQ_W     = RQ_DEPTH * 8;
    localparam int         RQ_CW    = $clog2(RQ_DEPTH + 1);
    localparam logic [7:0] MAX_LEN8 = 8'(MAX_CHUNK);

    bwr_state_e state_q, state_d, ret_q, ret_d;
    bwr_reply_e rp_sel;

    logic [7:0]  op_q, addr_cks, len_q, idx_q, data_cks;
    logic [31:0] addr_q;
    logic [2:0]  fld_cnt;
    logic        take, pop, rq_last, rq_load;
    logic [7:0]  rq_head, buf_byte;
    logic [RQ_W-1:0]  rq_bytes;
    logic [RQ_CW-1:0] rq_cnt;

    assign take = rx_valid && rx_ready;
    assign pop  = tx_poll && (state_q == ST_REPLY);

    // next-state and reply selection
    always_comb begin
        state_d = state_q;
        ret_d   = ret_q;
        rp_sel  = RP_NONE;
        unique case (state_q)
            ST_SYNC_LO: if (take && rx_data == SYNC_LO_B) state_d = ST_SYNC_HI;
            ST_SYNC_HI: if (take) begin
                if (rx_data == SYNC_HI_B) begin
                    rp_sel = RP_SYNC; ret_d = ST_CMD_A;
                end else begin
                    rp_sel = RP_NACK; ret_d = ST_SYNC_LO;
                end
            end
            ST_CMD_A:   if (take) state_d = ST_CMD_B;
            ST_CMD_B:   if (take) begin
                if (op_q == WR_OP && rx_data == WR_OP_N) begin
                    rp_sel = RP_ACK; ret_d = ST_ADDR;
                end else if (op_q == GO_OP && rx_data == GO_OP_N) begin
                    rp_sel = RP_GO; ret_d = ST_SYNC_LO;
                end else begin
                    rp_sel = RP_NACK; ret_d = ST_CMD_A;
                end
            end
            ST_ADDR:    if (take && fld_cnt == 3'd4) begin
                rp_sel = (rx_data == addr_cks) ? RP_ACK : RP_NACK;
                ret_d  = (rx_data == addr_cks) ? ST_LEN : ST_CMD_A;
            end
            ST_LEN:     if (take) begin
                if (rx_data != 8'h00 && rx_data <= MAX_LEN8) begin
                    rp_sel = RP_ACK; ret_d = ST_DATA;
                end else begin
                    rp_sel = RP_NACK; ret_d = ST_CMD_A;
                end
            end
            ST_DATA:    if (take && idx_q == len_q - 8'd1) state_d = ST_DCHK;
            ST_DCHK:    if (take) begin
                if (rx_data == data_cks) begin
                    state_d = ST_COMMIT;
                end else begin
                    rp_sel = RP_NACK; ret_d = ST_CMD_A;
                end
            end
            ST_COMMIT:  if (idx_q == len_q - 8'd1) begin
                rp_sel = RP_ACK; ret_d = ST_CMD_A;
            end
            ST_REPLY:   if (pop && rq_last) state_d = ret_q;
            default:    state_d = ST_SYNC_LO;
        endcase
        if (rp_sel != RP_NONE) state_d = ST_REPLY;
    end

    // reply contents
    always_comb begin
        rq_load  = (rp_sel != RP_NONE);
        rq_bytes = '0;
        rq_cnt   = RQ_CW'(1);
        unique case (rp_sel)
            RP_ACK:  rq_bytes[RQ_W-1 -: 8]  = BYTE_ACK;
            RP_NACK: rq_bytes[RQ_W-1 -: 8]  = BYTE_NACK;
            RP_SYNC: begin
                rq_bytes = {BYTE_ACK, INFO_WORD};
                rq_cnt   = RQ_CW'(RQ_DEPTH);
            end
            RP_GO:   begin
                rq_bytes[RQ_W-1 -: 16] = {BYTE_ACK, BYTE_FIN};
                rq_cnt   = RQ_CW'(2);
            end
            default: rq_cnt = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SYNC_LO;
            ret_q   <= ST_SYNC_LO;
        end else begin
            state_q <= state_d;
            ret_q   <= ret_d;
        end
    end

    // field capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= '0;
            addr_q   <= '0;
            addr_cks <= '0;
            fld_cnt  <= '0;
            len_q    <= '0;
            idx_q    <= '0;
            data_cks <= '0;
        end else begin
            if (state_q == ST_CMD_A && take) op_q <= rx_data;
            if (state_q == ST_CMD_B && take) begin
                fld_cnt  <= '0;
                addr_cks <= '0;
            end
            if (state_q == ST_ADDR && take && fld_cnt != 3'd4) begin
                addr_q   <= {addr_q[23:0], rx_data};
                addr_cks <= addr_cks ^ rx_data;
                fld_cnt  <= fld_cnt + 3'd1;
            end
            if (state_q == ST_LEN && take) begin
                len_q    <= rx_data;
                data_cks <= rx_data;
                idx_q    <= '0;
            end
            if (state_q == ST_DATA && take) begin
                data_cks <= data_cks ^ rx_data;
                idx_q    <= idx_q + 8'd1;
            end
            if (state_q == ST_DCHK && take) idx_q <= '0;
            if (state_q == ST_COMMIT)       idx_q <= idx_q + 8'd1;
        end
    end

    // outputs
    always_comb begin
        rx_ready  = (state_q != ST_REPLY) && (state_q != ST_COMMIT);
        tx_data   = (state_q == ST_REPLY) ? rq_head : 8'h00;
        mem_we    = (state_q == ST_COMMIT);
        mem_addr  = addr_q + {24'b0, idx_q};
        mem_wdata = buf_byte;
    end

    bwr_chunk_store #(.DEPTH(MAX_CHUNK)) u_store (
        .clk     (clk),
        .wr_en   (state_q == ST_DATA && take),
        .wr_idx  (idx_q[IDX_W-1:0]),
        .wr_byte (rx_data),
        .rd_idx  (idx_q[IDX_W-1:0]),
        .rd_byte (buf_byte)
    );

    bwr_reply_queue #(.DEPTH(RQ_DEPTH)) u_reply (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (rq_load),
        .load_bytes (rq_bytes),
        .load_cnt   (rq_cnt),
        .pop        (pop),
        .head       (rq_head),
        .last       (rq_last)
    );

endmodule

// File: rtl/bwr_checker.sv
module bwr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_ready,
    input logic        tx_poll,
    input logic [7:0]  tx_data,
    input logic        mem_we,
    input logic [31:0] mem_addr
);

    // R8: a state that takes bytes has no reply pending
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> tx_data == 8'h00);

    // R8: an unpolled reply byte is held
    p_reply_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_data != 8'h00 && !tx_poll) |=> $stable(tx_data));

    // R7: writes happen only while input is stalled and the reply is busy
    p_write_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (!rx_ready && tx_data == 8'h00));

    // R7: back-to-back writes step the address by one
    p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> mem_addr == $past(mem_addr) + 32'd1);

endmodule

bind boot_write_responder bwr_checker u_bwr_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_ready (rx_ready),
    .tx_poll  (tx_poll),
    .tx_data  (tx_data),
    .mem_we   (mem_we),
    .mem_addr (mem_addr)
);

// File: tb/boot_write_responder_tb_top.sv
`timescale 1ns/1ps
module boot_write_responder_tb_top;

    localparam logic [55:0] INFO = 56'hA1_B2_C3_D4_E5_F6_07;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_ready;
    logic        tx_poll = 1'b0;
    logic [7:0]  tx_data;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    int busy_reads;
    logic [39:0] exp_wr [$];

    always #2.5 clk = ~clk;

    boot_write_responder #(.INFO_WORD(INFO)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .tx_poll(tx_poll), .tx_data(tx_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock model comparison of the memory port
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (exp_wr.size() == 0) begin
                chk(1'b0, "R6 unexpected write", {mem_addr, mem_wdata}, 0);
            end else begin
                chk({mem_addr, mem_wdata} == exp_wr[0], "R7 write addr/data",
                    {mem_addr, mem_wdata}, exp_wr[0]);
                void'(exp_wr.pop_front());
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            chk(1'b0, "watchdog", cycles, 150000);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        while (!rx_ready) @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic expect_reply(input logic [7:0] exp, input string tag);
        logic [7:0] r;
        int guard = 0;
        r = 8'h00;
        while (r == 8'h00 && guard < 2000) begin
            @(negedge clk);
            tx_poll = 1'b1;
            r = tx_data;
            if (r == 8'h00) busy_reads++;
            guard++;
        end
        @(posedge clk);
        #1 tx_poll = 1'b0;
        chk(r == exp, tag, r, exp);
    endtask

    // bad: 0 none, 1 address check, 2 payload check
    task automatic write_chunk(input logic [31:0] a, input int n, input int seed,
                               input int bad, input string tag);
        logic [7:0] ck;
        logic [7:0] d;
        send(8'h31); send(8'hCE);
        expect_reply(8'h79, {tag, " R3 cmd ack"});
        ck = a[31:24] ^ a[23:16] ^ a[15:8] ^ a[7:0];
        send(a[31:24]); send(a[23:16]); send(a[15:8]); send(a[7:0]);
        send(bad == 1 ? ck ^ 8'h01 : ck);
        if (bad == 1) begin
            expect_reply(8'h1F, {tag, " R4 addr nack"});
            return;
        end
        expect_reply(8'h79, {tag, " R4 addr ack"});
        send(8'(n));
        if (n == 0 || n > 128) begin
            expect_reply(8'h1F, {tag, " R5 len nack"});
            return;
        end
        expect_reply(8'h79, {tag, " R5 len ack"});
        ck = 8'(n);
        for (int i = 0; i < n; i++) begin
            d = 8'(seed + i * 7);
            ck = ck ^ d;
            send(d);
        end
        if (bad == 2) begin
            send(ck ^ 8'hFF);
            expect_reply(8'h1F, {tag, " R6 data nack"});
            return;
        end
        for (int i = 0; i < n; i++) exp_wr.push_back({a + 32'(i), 8'(seed + i * 7)});
        busy_reads = 0;
        send(ck);
        expect_reply(8'h79, {tag, " R7 data ack"});
        chk(exp_wr.size() == 0, {tag, " R7 all writes done"}, exp_wr.size(), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rx_ready == 1'b1, "R1 rx_ready", rx_ready, 1);
        chk(tx_data == 8'h00, "R1 tx_data", tx_data, 0);
        chk(mem_we == 1'b0,   "R1 mem_we", mem_we, 0);

        // R2: junk ignored, bad second byte rejected, then good sync
        send(8'h55);
        repeat (3) @(negedge clk);
        chk(tx_data == 8'h00 && rx_ready, "R2 junk ignored", tx_data, 0);
        send(8'h00); send(8'h12);
        expect_reply(8'h1F, "R2 bad sync nack");
        send(8'h00); send(8'hFF);
        expect_reply(8'h79, "R2 sync ack");
        for (int k = 6; k >= 0; k--) expect_reply(INFO[k*8 +: 8], "R2 info byte");

        write_chunk(32'h1000_0040, 4, 8'h10, 0, "basic");

        // R3 unknown command then R10 retry
        send(8'h44); send(8'hBB);
        expect_reply(8'h1F, "R3 unknown cmd nack");
        write_chunk(32'h2000_0000, 3, 8'h20, 0, "R10 after cmd nack");

        write_chunk(32'h3000_00F0, 5, 8'h30, 1, "badaddr");
        write_chunk(32'h3000_00F0, 5, 8'h30, 0, "R10 after addr nack");

        write_chunk(32'h4000_0000, 0, 0, 0, "len0");
        write_chunk(32'h4000_0000, 129, 0, 0, "len81");
        write_chunk(32'h4000_FFC0, 128, 8'h40, 0, "len80");
        chk(busy_reads > 0, "R8 busy zero during commit", busy_reads, 1);

        write_chunk(32'h5000_0010, 6, 8'h50, 2, "badchk");
        chk(exp_wr.size() == 0, "R6 nothing queued", exp_wr.size(), 0);
        write_chunk(32'h5000_0010, 6, 8'h50, 0, "R10 after data nack");

        // R9 go, then closed session
        send(8'h21); send(8'hDE);
        expect_reply(8'h79, "R9 go ack");
        expect_reply(8'h51, "R9 go final");
        send(8'h31); send(8'hCE);
        repeat (4) @(negedge clk);
        chk(tx_data == 8'h00 && rx_ready, "R9 closed session ignores bytes", tx_data, 0);
        send(8'h00); send(8'hFF);
        expect_reply(8'h79, "R9 resync ack");
        for (int k = 6; k >= 0; k--) expect_reply(INFO[k*8 +: 8], "R9 resync info");

        repeat (5) @(negedge clk);
        chk(exp_wr.size() == 0, "R7 final queue empty", exp_wr.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule